// File: doc/BRIEF.md
# Serial FPGA configuration loader

This block programs a target FPGA over its serial slave configuration pins. A one-cycle start pulse begins a load. The block pulses the target's PROGRAM line and completes the INIT handshake. It then takes bitstream bytes from a valid/ready stream and shifts each one out on a data line against a generated configuration clock. After the byte flagged as last, it keeps that clock running with the data line high until the target raises DONE.

The block waits in three places: for INIT to go low, for INIT to return high, and for DONE. Each wait is bounded by a cycle-count timeout. While loading, the block also watches INIT against DONE at every byte boundary to catch a CRC failure reported by the target. When the load ends, the block drops busy and shows either a success flag or a failure flag with a two-bit code. Both stay unchanged until the next start.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start pulse while idle raises busy and PROGRAM on the next cycle. PROGRAM stays high until INIT is seen low.
- R2: After INIT is seen low, PROGRAM is released. No configuration clock edge occurs while PROGRAM is high or before INIT has returned high.
- R3: If INIT does not go low, or does not return high, within TIMEOUT_CYC cycles of entering that wait, the load ends. PROGRAM is low, busy is low, the fail flag is set and the fail code is 2'b01 (timeout).
- R4: Each byte goes out most-significant bit first, eight bits per byte, in the order in which the bytes were accepted.
- R5: The configuration clock idles high. The data line changes only while the configuration clock is low and was already low on the previous cycle, so it is stable at every rising edge.
- R6: Before a byte is accepted, if INIT is low while DONE is low, the load ends with the fail flag set and fail code 2'b10 (CRC error). That byte is not accepted.
- R7: byte_ready_o is high only while busy, between bytes, and never during the PROGRAM/INIT handshake or while idle.
- R8: After the last byte, the data line is held high and clock pulses continue until DONE is high. The block then ends with the ok flag set and fail code 2'b00.
- R9: If DONE is not seen within TIMEOUT_CYC cycles of the last byte, the load ends with fail code 2'b01.
- R10: A start pulse while busy has no effect. The ok/fail status and code hold their values while idle until the next start.
- R11: After reset: PROGRAM low, configuration clock high, busy, ok, fail and byte_ready_o low, fail code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle load request |
| byte_data_i | input | DATA_W | Bitstream byte |
| byte_valid_i | input | 1 | Byte present |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_ready_o | output | 1 | Byte accepted on this cycle when valid is high |
| prog_o | output | 1 | PROGRAM request to target, 1 = asserted |
| cclk_o | output | 1 | Configuration clock, target samples on rising edge |
| dout_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Target INIT line level |
| done_i | input | 1 | Target DONE line level |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load finished with DONE high |
| fail_o | output | 1 | Last load failed |
| fail_code_o | output | 2 | 00 none, 01 timeout, 10 CRC error |

## Verification
The bench builds the loader with HALF_CYC=2 and TIMEOUT_CYC=300. At the smallest divider, the cycle in which the data line updates falls directly between two clock ticks, which is the tightest case for the data-stability rule. The short timeout lets all three wait phases expire within a few hundred cycles, so each timeout path, the CRC abort at a byte boundary, and full loads of two different bitstreams all fit in one short run against a behavioural target model.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PROG_LOW,
      S_INIT_HIGH,
      S_BYTE,
      S_SHIFT,
      S_POST
   } ld_state_e;

   typedef enum logic [1:0] {
      FC_NONE    = 2'b00,
      FC_TIMEOUT = 2'b01,
      FC_CRC     = 2'b10
   } fail_code_e;

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
   parameter int HALF_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;

   if (HALF_CYC < 2) begin : g_bad_half
      $error("cfg_tick_gen: HALF_CYC must be at least 2");
   end

   if (HALF_CYC == 2) begin : g_toggle
      logic ph;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ph <= 1'b0;
         else if (!run) ph <= 1'b0;
         else           ph <= ~ph;
      end
      assign tick = run && ph;
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt <= '0;
         else if (!run)                       cnt <= '0;
         else if (cnt == CW'(HALF_CYC - 1))   cnt <= '0;
         else                                 cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CW'(HALF_CYC - 1));
   end

   // Ticks are never adjacent, which leaves a free cycle for the data update.
   a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/cfg_timeout.sv
module cfg_timeout #(
   parameter int LIMIT = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("cfg_timeout: LIMIT must be positive");
   end

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (cnt != TW'(LIMIT))     cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == TW'(LIMIT)) && !clr;

   a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !expired);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_load_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_CYC    = 5,
   parameter int TIMEOUT_CYC = 2_500_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              byte_valid_i,
   input  logic              byte_last_i,
   output logic              byte_ready_o,
   output logic              prog_o,
   output logic              cclk_o,
   output logic              dout_o,
   input  logic              init_i,
   input  logic              done_i,
   output logic              busy_o,
   output logic              ok_o,
   output logic              fail_o,
   output logic [1:0]        fail_code_o
);
   localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("cfg_serial_loader: DATA_W must be at least 2");
   end

   ld_state_e         st, st_prev;
   logic [DATA_W-1:0] sh;
   logic [BCW-1:0]    bitcnt;
   logic              last_q, cclk_q, dout_q, dpend;
   logic              ok_q, fail_q;
   fail_code_e        code_q;
   logic              tick, expired, tmo_clr, crc_bad, wait_st;

   assign wait_st = (st == S_PROG_LOW) || (st == S_INIT_HIGH) || (st == S_POST);
   assign tmo_clr = !wait_st || (st != st_prev);
   assign crc_bad = !init_i && !done_i;

   cfg_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n),
      .run((st == S_SHIFT) || (st == S_POST)),
      .tick(tick)
   );

   cfg_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .expired(expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         st_prev <= S_IDLE;
         sh      <= '0;
         bitcnt  <= '0;
         last_q  <= 1'b0;
         cclk_q  <= 1'b1;
         dout_q  <= 1'b0;
         dpend   <= 1'b0;
         ok_q    <= 1'b0;
         fail_q  <= 1'b0;
         code_q  <= FC_NONE;
      end else begin
         st_prev <= st;
         case (st)
            S_IDLE: begin
               if (start_i) begin
                  st     <= S_PROG_LOW;
                  ok_q   <= 1'b0;
                  fail_q <= 1'b0;
                  code_q <= FC_NONE;
               end
            end
            S_PROG_LOW: begin
               if (!init_i) st <= S_INIT_HIGH;
               else if (expired) begin
                  st <= S_IDLE; fail_q <= 1'b1; code_q <= FC_TIMEOUT;
               end
            end
            S_INIT_HIGH: begin
               if (init_i) st <= S_BYTE;
               else if (expired) begin
                  st <= S_IDLE; fail_q <= 1'b1; code_q <= FC_TIMEOUT;
               end
            end
            S_BYTE: begin
               if (crc_bad) begin
                  st <= S_IDLE; fail_q <= 1'b1; code_q <= FC_CRC;
               end else if (byte_valid_i) begin
                  sh     <= byte_data_i;
                  last_q <= byte_last_i;
                  bitcnt <= '0;
                  st     <= S_SHIFT;
               end
            end
            S_SHIFT: begin
               if (dpend) begin
                  dout_q <= sh[DATA_W-1];
                  sh     <= {sh[DATA_W-2:0], 1'b0};
                  dpend  <= 1'b0;
               end else if (tick) begin
                  if (cclk_q) begin
                     cclk_q <= 1'b0;
                     dpend  <= 1'b1;
                  end else begin
                     cclk_q <= 1'b1;
                     if (bitcnt == BCW'(DATA_W - 1)) st <= last_q ? S_POST : S_BYTE;
                     else                            bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            S_POST: begin
               if (done_i) begin
                  st <= S_IDLE; ok_q <= 1'b1; cclk_q <= 1'b1; dpend <= 1'b0;
               end else if (expired) begin
                  st <= S_IDLE; fail_q <= 1'b1; code_q <= FC_TIMEOUT;
                  cclk_q <= 1'b1; dpend <= 1'b0;
               end else if (dpend) begin
                  dout_q <= 1'b1;
                  dpend  <= 1'b0;
               end else if (tick) begin
                  cclk_q <= ~cclk_q;
                  dpend  <= cclk_q;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign prog_o       = (st == S_PROG_LOW);
   assign busy_o       = (st != S_IDLE);
   assign byte_ready_o = (st == S_BYTE) && !crc_bad;
   assign cclk_o       = cclk_q;
   assign dout_o       = dout_q;
   assign ok_o         = ok_q;
   assign fail_o       = fail_q;
   assign fail_code_o  = code_q;

   // R1: PROGRAM released only after INIT was seen low, or on a timeout
   a_r1_prog_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_o) |-> (fail_o || !$past(init_i)));
   // R2: configuration clock frozen high during the handshake
   a_r2_no_clk_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_PROG_LOW) || (st == S_INIT_HIGH)) |-> (cclk_o && $stable(cclk_o)));
   // R5: data moves only inside a low clock phase
   a_r5_dout_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_o) |-> (!cclk_o && !$past(cclk_o)));
   // R6: CRC condition at a byte boundary ends the load with the CRC code
   a_r6_crc_abort: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_BYTE) && crc_bad) |=> (fail_o && !busy_o && fail_code_o == 2'b10));
   // R7: ready only while busy with the clock parked high
   a_r7_ready_scope: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready_o |-> (busy_o && cclk_o && !prog_o));
   // R8: success only with DONE seen high
   a_r8_ok_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_o) |-> $past(done_i));
   // R10: status holds while idle without a start
   a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(fail_o) && $stable(fail_code_o)));

endmodule

// File: tb/cfg_serial_loader_tb.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb_top;

   localparam int HALF  = 2;
   localparam int TMO   = 300;
   localparam int NSTR  = 12;
   localparam logic [7:0] STREAM [NSTR] = '{
      8'hA5, 8'h3C, 8'h80, 8'h01, 8'hFF, 8'h00,
      8'h5A, 8'hC3, 8'h7E, 8'h81, 8'h96, 8'h69};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] byte_data_i = '0;
   logic       byte_valid_i = 1'b0;
   logic       byte_last_i = 1'b0;
   logic       byte_ready_o, prog_o, cclk_o, dout_o;
   logic       busy_o, ok_o, fail_o;
   logic [1:0] fail_code_o;
   logic       init_r, done_r;

   // target model controls (bench-driven)
   logic m_clear = 1'b1;
   int   m_init_mode = 0;   // 0 normal, 1 never low, 2 never returns high
   int   m_done_never = 0;
   int   m_crc_bits = 0;    // drop INIT after this many captured bits (0 = never)
   int   m_nbits = 0;

   // target model state (model-driven)
   logic       cclk_prev, dout_prev, crc_hit, post_bad, dout_bad;
   int         dly, bits, nby, extra, early_edges;
   logic [7:0] msh;
   logic [7:0] cap [16];

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   cfg_serial_loader #(.DATA_W(8), .HALF_CYC(HALF), .TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
      .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o),
      .prog_o(prog_o), .cclk_o(cclk_o), .dout_o(dout_o),
      .init_i(init_r), .done_i(done_r),
      .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o), .fail_code_o(fail_code_o));

   // Behavioural target: INIT handshake, capture on rising cclk, DONE after extra clocks
   always @(posedge clk) begin
      cclk_prev <= cclk_o;
      dout_prev <= dout_o;
      if (m_clear) begin
         init_r <= 1'b1; done_r <= 1'b0; crc_hit <= 1'b0; post_bad <= 1'b0;
         dout_bad <= 1'b0; dly <= 0; bits <= 0; nby <= 0; extra <= 0;
         early_edges <= 0; msh <= '0;
      end else begin
         if (dout_o != dout_prev && (cclk_o || cclk_prev)) dout_bad <= 1'b1;
         if (prog_o) begin
            if (m_init_mode != 1) begin
               if (dly < 5) dly <= dly + 1;
               else         init_r <= 1'b0;
            end
         end else if (!init_r && !crc_hit && m_init_mode != 2) begin
            if (dly != 0) dly <= dly - 1;
            else          init_r <= 1'b1;
         end
         if (m_crc_bits != 0 && bits == m_crc_bits && !crc_hit) begin
            crc_hit <= 1'b1; init_r <= 1'b0;
         end
         if (cclk_o && !cclk_prev) begin
            if (prog_o || (!init_r && !crc_hit)) early_edges <= early_edges + 1;
            else if (bits < m_nbits) begin
               msh  <= {msh[6:0], dout_o};
               bits <= bits + 1;
               if ((bits % 8) == 7) begin
                  cap[nby] <= {msh[6:0], dout_o};
                  nby <= nby + 1;
               end
            end else begin
               extra <= extra + 1;
               if (!dout_o) post_bad <= 1'b1;
               if (extra >= 2 && m_done_never == 0) done_r <= 1'b1;
            end
         end
      end
   end

   task automatic chk(input logic cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic feed(input int base, input int n);
      for (int i = 0; i < n; i++) begin
         byte_data_i  = STREAM[base+i];
         byte_last_i  = (i == n-1);
         byte_valid_i = 1'b1;
         while (!byte_ready_o && busy_o) @(negedge clk);
         if (!busy_o) break;
         @(negedge clk);
      end
      byte_valid_i = 1'b0;
      byte_last_i  = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy_o && n < 5000) begin @(negedge clk); n++; end
      chk(!busy_o, "watchdog-load", 1, 0);
   endtask

   task automatic begin_load(input int nbytes);
      m_clear = 1'b1; @(negedge clk); m_clear = 1'b0;
      m_nbits = nbytes * 8;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
   endtask

   task automatic check_stream(input int base, input int n, input string tag);
      chk(nby == n, tag, nby, n);
      for (int i = 0; i < n; i++)
         chk(cap[i] == STREAM[base+i], tag, cap[i], STREAM[base+i]);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!prog_o && cclk_o && !busy_o && !ok_o && !fail_o && !byte_ready_o && fail_code_o == 2'b00,
          "R11", {prog_o, cclk_o, busy_o, ok_o, fail_o, byte_ready_o}, 6'b010000);

      // Table-driven load of the first bitstream
      begin_load(6);
      chk(prog_o && busy_o && init_r, "R1", {prog_o, busy_o}, 2'b11);
      chk(!byte_ready_o, "R7", byte_ready_o, 0);
      feed(0, 6);
      wait_idle();
      check_stream(0, 6, "R4");
      chk(ok_o && !fail_o && fail_code_o == 2'b00, "R8", {ok_o, fail_o, fail_code_o}, 4'b1000);
      chk(extra >= 1 && !post_bad, "R8", extra, 3);
      chk(early_edges == 0, "R2", early_edges, 0);
      chk(!dout_bad && cclk_o, "R5", {dout_bad, cclk_o}, 2'b01);
      chk(!byte_ready_o, "R7", byte_ready_o, 0);

      // Second bitstream with start pulses while busy
      begin_load(6);
      fork
         feed(6, 6);
         begin
            repeat (30) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            repeat (40) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
         end
      join
      wait_idle();
      check_stream(6, 6, "R10");
      chk(ok_o && early_edges == 0, "R10", ok_o, 1);
      repeat (40) @(negedge clk);
      chk(ok_o && !fail_o && fail_code_o == 2'b00, "R10", {ok_o, fail_o}, 2'b10);

      // INIT never goes low
      m_init_mode = 1;
      begin_load(6);
      repeat (150) @(negedge clk);
      chk(busy_o && prog_o, "R3", busy_o, 1);
      wait_idle();
      chk(fail_o && fail_code_o == 2'b01 && !prog_o && !ok_o, "R3", fail_code_o, 1);
      chk(early_edges == 0, "R2", early_edges, 0);

      // INIT never returns high
      m_init_mode = 2;
      begin_load(6);
      wait_idle();
      chk(fail_o && fail_code_o == 2'b01 && !prog_o, "R3", fail_code_o, 1);
      chk(bits == 0, "R2", bits, 0);
      m_init_mode = 0;

      // CRC error reported during the second byte
      m_crc_bits = 15;
      begin_load(6);
      feed(0, 6);
      wait_idle();
      chk(fail_o && fail_code_o == 2'b10 && !ok_o, "R6", fail_code_o, 2);
      chk(nby == 2 && bits == 16, "R6", bits, 16);
      chk(!byte_ready_o, "R7", byte_ready_o, 0);
      m_crc_bits = 0;

      // DONE never rises
      m_done_never = 1;
      begin_load(6);
      feed(0, 6);
      wait_idle();
      chk(fail_o && fail_code_o == 2'b01 && !ok_o, "R9", fail_code_o, 1);
      chk(extra > 2 && !post_bad, "R9", extra, 3);
      check_stream(0, 6, "R4");
      m_done_never = 0;

      // Recovery load after failures
      begin_load(6);
      feed(6, 6);
      wait_idle();
      check_stream(6, 6, "R4");
      chk(ok_o && fail_code_o == 2'b00 && !dout_bad, "R8", ok_o, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule